// File: doc/BRIEF.md
# Virtual Function Routing-ID Decoder

This block sits beside a physical function that supports single-root I/O virtualization and answers one question for each request on the bus: does the incoming 8-bit device/function number address one of this function's virtual functions, and if so, which one? Virtual function `i` lives at the address formed by adding the function's own device/function number, a first-VF offset and `i` times a stride. The decoder works out the difference between the request and the first VF address. It divides that difference by the stride, and reports a hit when the division is exact and the quotient is below the number of currently active virtual functions.

The offset, stride, requested VF count, total VF count and the enable bit come from the function's capability registers and are presented as static inputs. The block also checks that the last VF the capability could create still has an address inside the 256-entry device/function space, and raises a configuration-error flag if it does not. While that flag condition holds, no request decodes. Responses are registered: the hit flag and the index arrive together one clock after the request.

Top module: `sriov_vf_decoder`

## Requirements
- R1: `rspValid` is high in the cycle after a cycle with `reqValid` high, and `rspHit`/`rspVfIdx` in that cycle belong to that request.
- R2: A request whose number equals `pfDevfn + vfOffset + i*vfStride`, with `i` below the active count, gives `rspHit`=1 and `rspVfIdx`=`i`.
- R3: A request below the first VF address, or whose distance from it is not a whole multiple of a nonzero stride, gives `rspHit`=0 and `rspVfIdx`=0.
- R4: A request that would resolve to an index equal to or above `numVfs` gives no hit.
- R5: When `vfEnable` is 0 the active count is zero and no request hits.
- R6: With `vfStride`=0 only the first VF address hits, always with index 0.
- R7: `cfgError` is 1 one cycle after a configuration where `totalVfs` is nonzero and `pfDevfn + vfOffset + (totalVfs-1)*vfStride` is 256 or more, and 0 one cycle after any other configuration (including `totalVfs`=0).
- R8: While the configuration satisfies the R7 error condition, no request hits.
- R9: When `numVfs` exceeds `totalVfs` the active count is zero and no request hits.
- R10: A request equal to `pfDevfn` never hits, even when `vfOffset` is 0.
- R11: In a cycle after `reqValid` was low, `rspValid`, `rspHit` and `rspVfIdx` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | A routing-ID lookup is presented this cycle |
| reqDevfn | input | 8 | Device/function number to decode |
| pfDevfn | input | 8 | Device/function number of the physical function |
| vfOffset | input | 16 | Distance from the PF to the first VF |
| vfStride | input | 16 | Distance between consecutive VFs |
| vfEnable | input | 1 | VF enable control bit |
| numVfs | input | 16 | Number of VFs software asked to activate |
| totalVfs | input | 16 | Number of VFs the capability can provide |
| rspValid | output | 1 | Registered response strobe |
| rspHit | output | 1 | Request matched an active VF |
| rspVfIdx | output | 8 | Index of the matched VF, 0 on a miss |
| cfgError | output | 1 | Registered VF address range overflow flag |

## Verification
The assertions relating a response to the previous cycle's inputs assume that the configuration inputs stay steady for the cycle in which a request is taken. The stimulus changes the capability fields only on the falling edge, before it issues a request, and leaves them alone until that request's response has been sampled. The bench computes expected hits by walking the VF index from zero and comparing addresses, instead of dividing. Stride zero, a stride larger than any distance, a zero offset that aliases the PF, and counts above the total are among the configurations it drives.

// File: rtl/sriov_dec_pkg.sv
package sriov_dec_pkg;

  // Strobes from the control half to the datapath half.
  typedef struct packed {
    logic capture;   // a request is being taken this cycle
    logic allowHit;  // configuration permits any VF to decode
  } decStrobe_t;

endpackage

// File: rtl/sriov_vf_ctrl.sv
module sriov_vf_ctrl
  import sriov_dec_pkg::*;
#(
  parameter int FN_W  = 8,
  parameter int CFG_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic [FN_W-1:0]  pfDevfn,
  input  logic [CFG_W-1:0] vfOffset,
  input  logic [CFG_W-1:0] vfStride,
  input  logic             vfEnable,
  input  logic [CFG_W-1:0] numVfs,
  input  logic [CFG_W-1:0] totalVfs,
  output decStrobe_t       strobe,
  output logic [CFG_W-1:0] activeCnt,
  output logic             cfgError
);

  localparam int LAST_W = 2 * CFG_W + FN_W + 2;
  localparam logic [LAST_W-1:0] DEVFN_SPAN = LAST_W'(1) << FN_W;

  logic [LAST_W-1:0] lastTerm;
  logic [LAST_W-1:0] lastAddr;
  logic              cfgBad;
  logic              countOk;

  // Address of the highest VF the capability could ever create.
  always_comb begin
    lastTerm = LAST_W'(totalVfs - CFG_W'(1)) * LAST_W'(vfStride);
    lastAddr = LAST_W'(pfDevfn) + LAST_W'(vfOffset) + lastTerm;
    cfgBad   = (totalVfs != '0) && (lastAddr >= DEVFN_SPAN);
  end

  // Active count collapses to zero when disabled or over-subscribed.
  always_comb begin
    countOk   = (numVfs <= totalVfs);
    activeCnt = (vfEnable && countOk) ? numVfs : '0;
  end

  always_comb begin
    strobe.capture  = reqValid;
    strobe.allowHit = reqValid && !cfgBad && (activeCnt != '0);
  end

  always_ff @(posedge clk) begin
    if (!rstN) cfgError <= 1'b0;
    else       cfgError <= cfgBad;
  end

  // R7: the flag only rises for a capability that advertises VFs.
  a_r7_err_needs_vfs: assert property (@(posedge clk) disable iff (!rstN)
    cfgError |-> ($past(totalVfs) != '0));

  // R9: permission to hit implies the requested count fit the total.
  a_r9_count_within_total: assert property (@(posedge clk) disable iff (!rstN)
    strobe.allowHit |-> (numVfs <= totalVfs));

endmodule

// File: rtl/sriov_vf_datapath.sv
module sriov_vf_datapath
  import sriov_dec_pkg::*;
#(
  parameter int FN_W  = 8,
  parameter int CFG_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  decStrobe_t       strobe,
  input  logic [FN_W-1:0]  reqDevfn,
  input  logic [FN_W-1:0]  pfDevfn,
  input  logic [CFG_W-1:0] vfOffset,
  input  logic [CFG_W-1:0] vfStride,
  input  logic [CFG_W-1:0] activeCnt,
  output logic             rspValid,
  output logic             rspHit,
  output logic [FN_W-1:0]  rspVfIdx
);

  localparam int BASE_W = CFG_W + 1;
  localparam int REM_W  = CFG_W + 1;

  logic [BASE_W-1:0] firstAddr;
  logic              belowFirst;
  logic [FN_W-1:0]   delta;
  logic              isPf;
  logic              strideZero;

  // Distance from the first VF address.
  always_comb begin
    firstAddr  = BASE_W'(pfDevfn) + BASE_W'(vfOffset);
    belowFirst = BASE_W'(reqDevfn) < firstAddr;
    delta      = reqDevfn - firstAddr[FN_W-1:0];
    isPf       = (reqDevfn == pfDevfn);
    strideZero = (vfStride == '0);
  end

  // Restoring division of delta by the stride, one stage per dividend bit.
  logic [REM_W-1:0] remChain [FN_W+1];
  logic [FN_W-1:0]  quot;

  assign remChain[0] = '0;

  for (genvar k = 0; k < FN_W; k++) begin : g_divStage
    localparam int BIT = FN_W - 1 - k;
    logic [REM_W-1:0] shifted;
    logic             fits;
    assign shifted          = {remChain[k][CFG_W-1:0], delta[BIT]};
    assign fits             = (shifted >= {1'b0, vfStride});
    assign quot[BIT]        = fits;
    assign remChain[k+1]    = fits ? (shifted - {1'b0, vfStride}) : shifted;
  end

  logic             exact;
  logic [FN_W-1:0]  idxNext;
  logic             hitNext;

  always_comb begin
    if (strideZero) begin
      exact   = (delta == '0);
      idxNext = '0;
    end else begin
      exact   = (remChain[FN_W] == '0);
      idxNext = quot;
    end
    hitNext = strobe.allowHit && !belowFirst && !isPf && exact &&
              (CFG_W'(idxNext) < activeCnt);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid <= 1'b0;
      rspHit   <= 1'b0;
      rspVfIdx <= '0;
    end else begin
      rspValid <= strobe.capture;
      rspHit   <= hitNext;
      rspVfIdx <= hitNext ? idxNext : '0;
    end
  end

  // R6: with a zero stride the only possible match is index 0.
  a_r6_zero_stride_idx: assert property (@(posedge clk) disable iff (!rstN)
    (rspHit && ($past(vfStride) == '0)) |-> (rspVfIdx == '0));

  // R3: a hit never comes from a request below the first VF address.
  a_r3_not_below_first: assert property (@(posedge clk) disable iff (!rstN)
    rspHit |-> ({1'b0, $past(reqDevfn)} >=
                 (BASE_W'($past(pfDevfn)) + BASE_W'($past(vfOffset)))));

  // R2: the reported index points back at the requested address.
  a_r2_index_consistent: assert property (@(posedge clk) disable iff (!rstN)
    rspHit |-> ((2*CFG_W+FN_W+2)'($past(pfDevfn)) +
                (2*CFG_W+FN_W+2)'($past(vfOffset)) +
                (2*CFG_W+FN_W+2)'(rspVfIdx) * (2*CFG_W+FN_W+2)'($past(vfStride))
                == (2*CFG_W+FN_W+2)'($past(reqDevfn))));

endmodule

// File: rtl/sriov_vf_decoder.sv
module sriov_vf_decoder
  import sriov_dec_pkg::*;
#(
  parameter int FN_W  = 8,
  parameter int CFG_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic [FN_W-1:0]  reqDevfn,
  input  logic [FN_W-1:0]  pfDevfn,
  input  logic [CFG_W-1:0] vfOffset,
  input  logic [CFG_W-1:0] vfStride,
  input  logic             vfEnable,
  input  logic [CFG_W-1:0] numVfs,
  input  logic [CFG_W-1:0] totalVfs,
  output logic             rspValid,
  output logic             rspHit,
  output logic [FN_W-1:0]  rspVfIdx,
  output logic             cfgError
);

  decStrobe_t       strobe;
  logic [CFG_W-1:0] activeCnt;

  sriov_vf_ctrl #(.FN_W(FN_W), .CFG_W(CFG_W)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .pfDevfn  (pfDevfn),
    .vfOffset (vfOffset),
    .vfStride (vfStride),
    .vfEnable (vfEnable),
    .numVfs   (numVfs),
    .totalVfs (totalVfs),
    .strobe   (strobe),
    .activeCnt(activeCnt),
    .cfgError (cfgError)
  );

  sriov_vf_datapath #(.FN_W(FN_W), .CFG_W(CFG_W)) u_datapath (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .reqDevfn (reqDevfn),
    .pfDevfn  (pfDevfn),
    .vfOffset (vfOffset),
    .vfStride (vfStride),
    .activeCnt(activeCnt),
    .rspValid (rspValid),
    .rspHit   (rspHit),
    .rspVfIdx (rspVfIdx)
  );

  // R1: a response only follows a request.
  a_r1_rsp_after_req: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> $past(reqValid));

  // R11: idle cycles leave the response fields at zero.
  a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !rspValid |-> (!rspHit && (rspVfIdx == '0)));

  // R4: hit index stays below the requested count.
  a_r4_idx_below_count: assert property (@(posedge clk) disable iff (!rstN)
    rspHit |-> (CFG_W'(rspVfIdx) < $past(numVfs)));

  // R5: no hit while VFs are disabled.
  a_r5_needs_enable: assert property (@(posedge clk) disable iff (!rstN)
    rspHit |-> $past(vfEnable));

  // R8: an overflowing configuration never yields a hit.
  a_r8_no_hit_on_error: assert property (@(posedge clk) disable iff (!rstN)
    rspHit |-> !cfgError);

  // R10: the PF's own number is never decoded as a VF.
  a_r10_pf_not_vf: assert property (@(posedge clk) disable iff (!rstN)
    rspHit |-> ($past(reqDevfn) != $past(pfDevfn)));

endmodule

// File: tb/sriov_vf_decoder_bench.sv
module sriov_vf_decoder_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [7:0]  reqDevfn = '0;
  logic [7:0]  pfDevfn = '0;
  logic [15:0] vfOffset = '0;
  logic [15:0] vfStride = '0;
  logic        vfEnable = 1'b0;
  logic [15:0] numVfs = '0;
  logic [15:0] totalVfs = '0;
  logic        rspValid;
  logic        rspHit;
  logic [7:0]  rspVfIdx;
  logic        cfgError;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  sriov_vf_decoder u_sriov_vf_decoder (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqDevfn(reqDevfn),
    .pfDevfn(pfDevfn), .vfOffset(vfOffset), .vfStride(vfStride),
    .vfEnable(vfEnable), .numVfs(numVfs), .totalVfs(totalVfs),
    .rspValid(rspValid), .rspHit(rspHit), .rspVfIdx(rspVfIdx),
    .cfgError(cfgError)
  );

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Reference from the requirements: walk indices, compare addresses.
  function automatic void refDecode(int devfn, output bit hit, output int idx);
    int active;
    bit bad;
    hit = 0;
    idx = 0;
    active = (vfEnable && numVfs <= totalVfs) ? int'(numVfs) : 0;
    bad = (totalVfs != 0) &&
          (longint'(pfDevfn) + longint'(vfOffset) +
           (longint'(totalVfs) - 1) * longint'(vfStride) >= 256);
    if (bad || devfn == int'(pfDevfn)) return;
    for (int i = 0; i < active; i++) begin
      if (longint'(pfDevfn) + longint'(vfOffset) + longint'(i) * longint'(vfStride)
          == longint'(devfn)) begin
        hit = 1;
        idx = i;
        return;
      end
    end
  endfunction

  task automatic setCfg(int pf, int off, int stride, bit en, int num, int total);
    @(negedge clk);
    pfDevfn = 8'(pf); vfOffset = 16'(off); vfStride = 16'(stride);
    vfEnable = en; numVfs = 16'(num); totalVfs = 16'(total);
  endtask

  task automatic runReq(int devfn, bit expHit, int expIdx, string req);
    @(negedge clk);
    reqValid = 1'b1;
    reqDevfn = 8'(devfn);
    @(negedge clk);
    reqValid = 1'b0;
    check(rspValid == 1'b1, {req, " rspValid"}, int'(rspValid), 1);
    check(rspHit == expHit, {req, " rspHit"}, int'(rspHit), int'(expHit));
    check(int'(rspVfIdx) == expIdx, {req, " rspVfIdx"}, int'(rspVfIdx), expIdx);
  endtask

  task automatic testReset();
    @(negedge clk);
    check(rspValid == 0 && rspHit == 0 && rspVfIdx == 0, "R11 reset outputs",
          int'(rspHit), 0);
    check(cfgError == 0, "R7 reset cfgError", int'(cfgError), 0);
  endtask

  task automatic testBasic();
    // VFs at 12, 14, ... ; eight active
    setCfg(8, 4, 2, 1, 8, 16);
    runReq(12, 1, 0, "R2 first VF");
    runReq(18, 1, 3, "R2 middle VF");
    runReq(26, 1, 7, "R2 last active VF");
    runReq(13, 0, 0, "R3 between strides");
    runReq(11, 0, 0, "R3 below first VF");
    runReq(28, 0, 0, "R4 index equals count");
    runReq(40, 0, 0, "R4 index beyond count");
  endtask

  task automatic testLatency();
    // back-to-back requests; each response belongs to its own request
    setCfg(8, 4, 2, 1, 8, 16);
    @(negedge clk);
    reqValid = 1; reqDevfn = 8'd14;
    @(negedge clk);
    check(rspHit == 1 && rspVfIdx == 1, "R1 pipelined first", int'(rspVfIdx), 1);
    reqDevfn = 8'd20;
    @(negedge clk);
    check(rspHit == 1 && rspVfIdx == 4, "R1 pipelined second", int'(rspVfIdx), 4);
    reqValid = 0;
    @(negedge clk);
    check(rspValid == 0, "R1 valid drops", int'(rspValid), 0);
  endtask

  task automatic testIdle();
    setCfg(8, 4, 2, 1, 8, 16);
    @(negedge clk);
    reqValid = 0; reqDevfn = 8'd12;
    @(negedge clk);
    check(rspValid == 0 && rspHit == 0 && rspVfIdx == 0, "R11 idle request ignored",
          int'(rspHit), 0);
  endtask

  task automatic testDisable();
    setCfg(8, 4, 2, 0, 8, 16);
    runReq(12, 0, 0, "R5 disabled first VF");
    runReq(16, 0, 0, "R5 disabled other VF");
  endtask

  task automatic testZeroStride();
    setCfg(16, 3, 0, 1, 4, 4);
    runReq(19, 1, 0, "R6 zero stride base");
    runReq(20, 0, 0, "R6 zero stride next");
  endtask

  task automatic testWideStride();
    // stride larger than any distance: only index 0 exists
    setCfg(2, 1, 300, 1, 1, 1);
    runReq(3, 1, 0, "R2 wide stride base");
    runReq(4, 0, 0, "R3 wide stride miss");
  endtask

  task automatic testCfgError();
    setCfg(0, 1, 2, 1, 1, 128);
    @(negedge clk);
    check(cfgError == 0, "R7 last VF at 255 ok", int'(cfgError), 0);
    runReq(1, 1, 0, "R8 valid config decodes");
    setCfg(0, 1, 2, 1, 1, 129);
    @(negedge clk);
    check(cfgError == 1, "R7 last VF at 257", int'(cfgError), 1);
    runReq(1, 0, 0, "R8 overflow blocks hit");
    setCfg(250, 10, 2, 0, 0, 0);
    @(negedge clk);
    check(cfgError == 0, "R7 zero total no error", int'(cfgError), 0);
  endtask

  task automatic testOverCount();
    setCfg(8, 4, 2, 1, 20, 16);
    runReq(12, 0, 0, "R9 count above total");
  endtask

  task automatic testPfAlias();
    setCfg(5, 0, 1, 1, 4, 4);
    runReq(5, 0, 0, "R10 PF number not a VF");
    runReq(6, 1, 1, "R10 neighbour VF decodes");
  endtask

  task automatic testSweep();
    bit h;
    int i;
    setCfg(3, 7, 3, 1, 20, 40);
    for (int d = 0; d < 256; d += 5) begin
      refDecode(d, h, i);
      runReq(d, h, i, "R2 R3 sweep");
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testBasic();
    testLatency();
    testIdle();
    testDisable();
    testZeroStride();
    testWideStride();
    testCfgError();
    testOverCount();
    testPfAlias();
    testSweep();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #1000000;
    if (!finished) begin
      finished = 1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule